// File: doc/BRIEF.md
# Master Interrupt Gate

This block is the top-level interrupt control point of a device. It collects one level indication from each lower interrupt unit (two engine banks and a miscellaneous unit in the default build) and drives one interrupt line to the host. It holds one writable bit, the master enable. The host line is high only while that bit is set and at least one lower indication is active.

The service routine first writes zero to drop the master enable, which quiets the host line. It then reads the register to get a snapshot of which lower groups are asking for service, and acknowledges those lower units. Finally it sets the enable again. The indication bits follow the lower units' levels and never latch. Dropping the enable therefore loses nothing: any source still active, or raised during servicing, brings the host line back up once the enable returns.

Indications are registered once on entry, and the host line is registered once after the gate. Reset is asynchronous on assertion and released in step with the clock.

Top module: `irq_master_gate`

## Requirements
- R1: While reset is held and right after its release, the enable bit reads 0, every indication bit reads 0 and `host_irq` is low.
- R2: A write whose bit 31 is 0 clears the enable (readable one cycle after the write edge), and `host_irq` is low from the cycle after that, whatever the indications are.
- R3: With the enable off, a read shows the level of each lower source, one clock after that level is applied.
- R4: An indication bit follows its source level only. A register write of any value, including ones at indication positions, neither sets nor clears it.
- R5: An indication that rises while the enable is off leaves `host_irq` low, and raises `host_irq` once a write sets the enable again.
- R6: The field positions are fixed: bit 0 is engine bank 0, bit 1 is engine bank 1, bit 2 is the miscellaneous unit, and bit 31 is the master enable. A write whose bit 31 is 1 sets the enable.
- R7: The read value is never all ones, even with every source active and the enable set.
- R8: `host_irq` equals the registered enable ANDed with the OR of the registered indications, delayed by one clock.
- R9: Bits between the highest indication and the enable always read 0, and writes to them have no effect.
- R10: A write that sets the enable in the same cycle as a source rises gives both the enable and the indication on the following read, and `host_irq` high one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data (only bit 31 is used) |
| reg_rdata | output | 32 | Register read value: enable in bit 31, indications in the low bits |
| src_level | input | 3 | Level indications from the lower units (bank 0, bank 1, misc) |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
Two things can land on the same clock edge: a register write that changes the enable, and a change in a lower source level. The bench makes them coincide in both directions. It sets the enable on the edge where a source rises. It also clears the enable while sources stay active, and writes all ones while every source is active. In each case it judges the readback one cycle after the edge and the host line two cycles after it, checking that neither event hides the other.

// File: rtl/irq_mg_pkg.sv
package irq_mg_pkg;
  typedef enum int unsigned {
    SRC_BANK0 = 0,
    SRC_BANK1 = 1,
    SRC_MISC  = 2
  } src_idx_e;

  localparam int unsigned MIN_SRC = 3;

  function automatic logic any_active(input logic en, input logic hit);
    return en & hit;
  endfunction
endpackage

// File: rtl/irq_mg_rst_sync.sv
module irq_mg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_mg_level_capture.sv
module irq_mg_level_capture #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  output logic [NUM_SRC-1:0] ind_q
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic lvl_d;
    logic lvl_q;

    always_comb begin
      lvl_d = src_level[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_d;
    end

    assign ind_q[g] = lvl_q;
  end
endmodule

// File: rtl/irq_mg_enable_reg.sv
module irq_mg_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic en_q
);
  logic en_d;
  logic en_ce;

  always_comb begin
    en_ce = wr_stb;
    en_d  = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end
endmodule

// File: rtl/irq_mg_gate.sv
module irq_mg_gate #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_q,
  input  logic [NUM_SRC-1:0] ind_q,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_q
);
  import irq_mg_pkg::*;

  localparam int unsigned EN_BIT = DATA_W - 1;

  logic irq_d;

  always_comb begin
    irq_d = any_active(en_q, |ind_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    rdata                = '0;
    rdata[NUM_SRC-1:0]   = ind_q;
    rdata[EN_BIT]        = en_q;
  end
endmodule

// File: rtl/irq_master_gate.sv
module irq_master_gate #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_SRC     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] src_level,
  output logic               host_irq
);
  localparam int unsigned EN_BIT = DATA_W - 1;

  if (NUM_SRC + 2 > DATA_W) begin : g_bad_width
    $error("NUM_SRC must leave at least one reserved bit below the enable");
  end

  logic               rst_sync_n;
  logic               en_q;
  logic [NUM_SRC-1:0] ind_q;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata[EN_BIT-1:0];

  irq_mg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_mg_level_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_level (src_level),
    .ind_q     (ind_q)
  );

  irq_mg_enable_reg u_en (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_stb (reg_wr),
    .wr_bit (reg_wdata[EN_BIT]),
    .en_q   (en_q)
  );

  irq_mg_gate #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_gate (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_q  (en_q),
    .ind_q (ind_q),
    .rdata (reg_rdata),
    .irq_q (host_irq)
  );
endmodule

// File: rtl/irq_master_gate_chk.sv
module irq_master_gate_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 3
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               reg_wr,
  input logic               wr_en_bit,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [NUM_SRC-1:0] src_level,
  input logic               host_irq
);
  localparam int unsigned EN_BIT = DATA_W - 1;

  a_r8_irq_high: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rdata[EN_BIT] && |reg_rdata[NUM_SRC-1:0]) |=> host_irq);

  a_r8_irq_low: assert property (@(posedge clk) disable iff (!rst_ok)
    !(reg_rdata[EN_BIT] && |reg_rdata[NUM_SRC-1:0]) |=> !host_irq);

  a_r2_clear_en: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_wr && !wr_en_bit) |=> !reg_rdata[EN_BIT]);

  a_r6_set_en: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_wr && wr_en_bit) |=> reg_rdata[EN_BIT]);

  a_r4_follow_src: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> (reg_rdata[NUM_SRC-1:0] == $past(src_level)));

  a_r7_not_all_ones: assert property (@(posedge clk) disable iff (!rst_ok)
    reg_rdata != {DATA_W{1'b1}});

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    reg_rdata[EN_BIT-1:NUM_SRC] == '0);
endmodule

bind irq_master_gate irq_master_gate_chk #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .reg_wr    (reg_wr),
  .wr_en_bit (reg_wdata[DATA_W-1]),
  .reg_rdata (reg_rdata),
  .src_level (src_level),
  .host_irq  (host_irq)
);

// File: tb/irq_master_gate_tb.sv
module irq_master_gate_tb;
  localparam int unsigned DW = 32;
  localparam int unsigned NS = 3;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic [NS-1:0] src_level;
  logic          host_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_master_gate #(.DATA_W(DW), .NUM_SRC(NS)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_level (src_level),
    .host_irq  (host_irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_exp(input logic en, input logic [NS-1:0] pat);
    logic [DW-1:0] v;
    v = '0;
    v[NS-1:0] = pat;
    v[DW-1] = en;
    return v;
  endfunction

  // write at a falling edge; returns at the next falling edge with the write taken
  task automatic wr(input logic [DW-1:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_wdata = '0;
    src_level = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset held, even with sources driven
    src_level = 3'b111;
    @(negedge clk);
    chk("R1 rdata in reset", reg_rdata, '0);
    chk("R1 irq in reset", {31'b0, host_irq}, '0);
    src_level = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rdata after release", reg_rdata, '0);
    chk("R1 irq after release", {31'b0, host_irq}, '0);

    // R3/R8/R6: sweep every pattern with enable off and on
    for (int en = 0; en < 2; en++) begin
      wr(rd_exp(en[0], '0));
      for (int p = 0; p < (1 << NS); p++) begin
        src_level = p[NS-1:0];
        @(negedge clk);
        chk("R3 R6 readback", reg_rdata, rd_exp(en[0], p[NS-1:0]));
        @(negedge clk);
        chk("R8 irq gate", {31'b0, host_irq}, {31'b0, en[0] & (p != 0)});
      end
    end

    // R6: single-source bit positions with enable on
    src_level = 3'b001; @(negedge clk);
    chk("R6 bank0 bit0", reg_rdata, 32'h8000_0001);
    src_level = 3'b010; @(negedge clk);
    chk("R6 bank1 bit1", reg_rdata, 32'h8000_0002);
    src_level = 3'b100; @(negedge clk);
    chk("R6 misc bit2", reg_rdata, 32'h8000_0004);

    // R2/R4: clear enable with an active source; indication retained
    src_level = 3'b001;
    repeat (2) @(negedge clk);
    chk("R2 irq before clear", {31'b0, host_irq}, 32'h1);
    wr(32'h0000_0007);
    chk("R2 R4 enable cleared, ind kept", reg_rdata, 32'h0000_0001);
    @(negedge clk);
    chk("R2 irq dropped", {31'b0, host_irq}, 32'h0);

    // R4/R9: write ones to indication/reserved bits with source idle
    src_level = 3'b000;
    @(negedge clk);
    wr(32'h7FFF_FFFF);
    chk("R4 R9 writes ignored", reg_rdata, 32'h0);

    // R5: rise while disabled, then enable
    src_level = 3'b100;
    repeat (2) @(negedge clk);
    chk("R5 irq held low while off", {31'b0, host_irq}, 32'h0);
    chk("R5 ind visible while off", reg_rdata, 32'h0000_0004);
    wr(32'h8000_0000);
    chk("R5 enable set", reg_rdata, 32'h8000_0004);
    @(negedge clk);
    chk("R5 irq reasserted", {31'b0, host_irq}, 32'h1);

    // R10: enable write and source rise on the same edge
    wr(32'h0);
    src_level = 3'b000;
    repeat (2) @(negedge clk);
    chk("R10 idle", {31'b0, host_irq}, 32'h0);
    src_level = 3'b010;
    wr(32'h8000_0000);
    chk("R10 both visible", reg_rdata, 32'h8000_0002);
    chk("R10 irq not yet", {31'b0, host_irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq high", {31'b0, host_irq}, 32'h1);

    // R7/R9: all sources active plus all-ones write
    src_level = 3'b111;
    wr(32'hFFFF_FFFF);
    chk("R7 R9 not all ones", reg_rdata, 32'h8000_0007);
    checks++;
    if (reg_rdata === 32'hFFFF_FFFF) begin
      failures++;
      $display("FAIL R7 actual=0x%08h expected=not 0xffffffff", reg_rdata);
    end

    // R4: indication drops only with the source
    src_level = 3'b101;
    @(negedge clk);
    chk("R4 drop on source ack", reg_rdata, 32'h8000_0005);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule